// File: doc/BRIEF.md
# Hashed Flag-Array Event Counter

This block counts events per counter ID without a read-modify-write on the event path. An event only stores a fixed non-zero mark into a small flag array. The slots it marks are picked by several hash functions of the ID. A background scanner sweeps the array one slot per cycle. Each time it finds a marked slot, it adds one to that slot's accumulator and clears the mark.

A query port returns the estimate for an ID. The estimate is the smallest accumulator among the ID's hashed slots, so a collision on one slot is masked by the others, as in a counting Bloom filter. Several events that land on a slot between two scanner visits count as one. That loss is accepted as statistical error.

The scanner is a two-state machine. START is the state held during reset. The transition *go* takes it to SWEEP on the first clock edge after reset is released. The transition *step* keeps it in SWEEP on every later edge and advances the slot pointer. The transition *wrap* moves the pointer from the last slot back to slot 0. Asserting reset returns the machine to START.

Top module: `hfc_event_counter`

## Requirements
- R1: While reset is asserted, and right after it, every flag slot and every accumulator is zero, so a query for any ID returns 0.
- R2: An event (`ev_valid` high at a clock edge) stores the fixed non-zero mark into each of its hashed slots at that edge, with no dependence on the slot's old value.
- R3: Count the clock edges after reset release, starting at edge 0. Edge 0 takes the scanner from START to SWEEP and visits no slot. Edge n (n >= 1) visits slot (n-1) mod NUM_SLOTS. A visited slot whose flag was non-zero before the edge adds one to its accumulator at that edge and clears its flag.
- R4: With lo = id[IDX_W-1:0] and hi = id[2*IDX_W-1:IDX_W], hash k (k = 0 .. NUM_HASH-1) selects slot (lo + (2k+1)*hi) mod NUM_SLOTS. With the defaults this gives h0 = lo+hi and h1 = lo+3*hi, mod 16.
- R5: `qry_count` is the minimum of the accumulators at the hashed slots of `qry_id`, available combinationally in the same cycle. Because of this, an ID can be over-estimated only when all of its slots collide with other IDs.
- R6: Any number of events that mark a slot between two scanner visits to it add exactly one to that slot's accumulator.
- R7: When an event marks a slot on the same edge that the scanner clears it, the mark stays set, so the slot is counted again on the next sweep.
- R8: An accumulator at its maximum value (all ones) stays there when it is incremented again. It never wraps.
- R9: After visiting slot NUM_SLOTS-1, the scanner visits slot 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | Records an event for `ev_id` at this edge |
| ev_id | input | ID_W | Counter ID of the event |
| qry_id | input | ID_W | Counter ID being queried |
| qry_count | output | CNT_W | Minimum-of-slots estimate for `qry_id` |

## Verification
The assertions assume that `ev_valid` is never unknown out of reset, and that `ev_id` and `qry_id` are known whenever they are used. The assertions also rely on NUM_SLOTS being a power of two and ID_W being at least twice the slot index width. The bench keeps within these limits by driving every input at the falling edge, so each value is stable across the rising edge that samples it. It also holds `ev_id` at a defined value even while `ev_valid` is low. Tests that depend on scanner phase compute the next visited slot from their own count of edges since reset release.

// File: rtl/hfc_pkg.sv
package hfc_pkg;

    typedef enum logic [0:0] {
        ST_START = 1'b0,
        ST_SWEEP = 1'b1
    } scan_state_t;

endpackage

// File: rtl/hfc_hash.sv
module hfc_hash #(
    parameter int ID_W     = 8,
    parameter int IDX_W    = 4,
    parameter int NUM_HASH = 2
) (
    input  logic [ID_W-1:0]                 id,
    output logic [NUM_HASH-1:0][IDX_W-1:0]  idx
);

    logic [IDX_W-1:0] lo_part;
    logic [IDX_W-1:0] hi_part;

    assign lo_part = id[IDX_W-1:0];
    assign hi_part = id[2*IDX_W-1:IDX_W];

    // Each hash uses its own odd multiplier on the upper half.
    for (genvar k = 0; k < NUM_HASH; k++) begin : g_hash
        localparam logic [IDX_W-1:0] MUL = IDX_W'(2 * k + 1);
        assign idx[k] = lo_part + MUL * hi_part;
    end

endmodule

// File: rtl/hfc_flag_array.sv
module hfc_flag_array #(
    parameter int                NUM_SLOTS = 16,
    parameter int                IDX_W     = 4,
    parameter int                NUM_HASH  = 2,
    parameter int                FLAG_W    = 8,
    parameter logic [FLAG_W-1:0] FLAG_MARK = 8'h5A
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ev_valid,
    input  logic [NUM_HASH-1:0][IDX_W-1:0]  ev_idx,
    input  logic [IDX_W-1:0]                scan_idx,
    input  logic                            scan_clear,
    output logic                            scan_nz
);

    logic [FLAG_W-1:0]    flag_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] ev_hit;
    logic [NUM_SLOTS-1:0] clr_hit;

    always_comb begin
        ev_hit = '0;
        for (int k = 0; k < NUM_HASH; k++) begin
            if (ev_valid) begin
                ev_hit[ev_idx[k]] = 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        assign clr_hit[i] = scan_clear && (scan_idx == IDX_W'(i));

        // A mark from an event takes precedence over a scanner clear.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[i] <= '0;
            end else if (ev_hit[i]) begin
                flag_q[i] <= FLAG_MARK;
            end else if (clr_hit[i]) begin
                flag_q[i] <= '0;
            end
        end

        assert_event_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ev_hit[i] |=> (flag_q[i] == FLAG_MARK));

        assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_hit[i] && !ev_hit[i]) |=> (flag_q[i] == '0));

        assert_flag_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!ev_hit[i] && !clr_hit[i]) |=> $stable(flag_q[i]));
    end

    assign scan_nz = |flag_q[scan_idx];

    assert_one_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_hit));

endmodule

// File: rtl/hfc_scanner.sv
module hfc_scanner
    import hfc_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flag_nz,
    output logic [IDX_W-1:0] scan_idx,
    output logic             harvest
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

    scan_state_t      state_q, state_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_START;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // Next state: go (START->SWEEP), step and wrap (SWEEP->SWEEP).
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_START: begin
                state_d = ST_SWEEP;
                ptr_d   = '0;
            end
            ST_SWEEP: begin
                state_d = ST_SWEEP;
                ptr_d   = (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
            end
            default: begin
                state_d = ST_START;
                ptr_d   = '0;
            end
        endcase
    end

    always_comb begin
        scan_idx = ptr_q;
        harvest  = 1'b0;
        unique case (state_q)
            ST_START: harvest = 1'b0;
            ST_SWEEP: harvest = flag_nz;
            default:  harvest = 1'b0;
        endcase
    end

    assert_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START) |=> (state_q == ST_SWEEP && ptr_q == '0));

    assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWEEP && ptr_q == LAST_IDX) |=> (ptr_q == '0));

    assert_stay_sweep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWEEP) |=> (state_q == ST_SWEEP));

endmodule

// File: rtl/hfc_accum_bank.sv
module hfc_accum_bank #(
    parameter int NUM_SLOTS = 16,
    parameter int IDX_W     = 4,
    parameter int NUM_HASH  = 2,
    parameter int CNT_W     = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            harvest,
    input  logic [IDX_W-1:0]                scan_idx,
    input  logic [NUM_HASH-1:0][IDX_W-1:0]  qry_idx,
    output logic [CNT_W-1:0]                qry_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0]     acc_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] inc;
    logic [CNT_W-1:0]     slot_val [NUM_HASH];

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_acc
        assign inc[i] = harvest && (scan_idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q[i] <= '0;
            end else if (inc[i] && (acc_q[i] != CNT_MAX)) begin
                acc_q[i] <= acc_q[i] + 1'b1;
            end
        end

        assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (inc[i] && acc_q[i] == CNT_MAX) |=> (acc_q[i] == CNT_MAX));

        assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (inc[i] && acc_q[i] != CNT_MAX) |=> (acc_q[i] == $past(acc_q[i]) + CNT_W'(1)));

        assert_acc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !inc[i] |=> $stable(acc_q[i]));
    end

    for (genvar k = 0; k < NUM_HASH; k++) begin : g_sel
        assign slot_val[k] = acc_q[qry_idx[k]];

        assert_min_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
            qry_count <= slot_val[k]);
    end

    always_comb begin
        qry_count = slot_val[0];
        for (int k = 1; k < NUM_HASH; k++) begin
            if (slot_val[k] < qry_count) begin
                qry_count = slot_val[k];
            end
        end
    end

endmodule

// File: rtl/hfc_event_counter.sv
module hfc_event_counter #(
    parameter int                ID_W      = 8,
    parameter int                NUM_SLOTS = 16,
    parameter int                NUM_HASH  = 2,
    parameter int                CNT_W     = 8,
    parameter int                FLAG_W    = 8,
    parameter logic [FLAG_W-1:0] FLAG_MARK = 8'h5A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic [ID_W-1:0]  ev_id,
    input  logic [ID_W-1:0]  qry_id,
    output logic [CNT_W-1:0] qry_count
);

    localparam int IDX_W = $clog2(NUM_SLOTS);

    logic [NUM_HASH-1:0][IDX_W-1:0] ev_idx;
    logic [NUM_HASH-1:0][IDX_W-1:0] qry_idx;
    logic [IDX_W-1:0]               scan_idx;
    logic                           scan_nz;
    logic                           harvest;

    hfc_hash #(.ID_W(ID_W), .IDX_W(IDX_W), .NUM_HASH(NUM_HASH)) u_ev_hash (
        .id  (ev_id),
        .idx (ev_idx)
    );

    hfc_hash #(.ID_W(ID_W), .IDX_W(IDX_W), .NUM_HASH(NUM_HASH)) u_qry_hash (
        .id  (qry_id),
        .idx (qry_idx)
    );

    hfc_flag_array #(
        .NUM_SLOTS (NUM_SLOTS),
        .IDX_W     (IDX_W),
        .NUM_HASH  (NUM_HASH),
        .FLAG_W    (FLAG_W),
        .FLAG_MARK (FLAG_MARK)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_valid   (ev_valid),
        .ev_idx     (ev_idx),
        .scan_idx   (scan_idx),
        .scan_clear (harvest),
        .scan_nz    (scan_nz)
    );

    hfc_scanner #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_nz  (scan_nz),
        .scan_idx (scan_idx),
        .harvest  (harvest)
    );

    hfc_accum_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .IDX_W     (IDX_W),
        .NUM_HASH  (NUM_HASH),
        .CNT_W     (CNT_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .harvest   (harvest),
        .scan_idx  (scan_idx),
        .qry_idx   (qry_idx),
        .qry_count (qry_count)
    );

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |-> (qry_count == '0));

endmodule

// File: tb/tb_hfc_event_counter.sv
module tb_hfc_event_counter;

    localparam int CLK_PERIOD = 10;
    localparam int NSLOT      = 16;

    // Row: fire(1) fire_id(8) qry_id(8) expected(8)
    localparam logic [24:0] VEC [8] = '{
        {1'b1, 8'h12, 8'h12, 8'd1},   // R2 R4: slots 3 and 5
        {1'b1, 8'h12, 8'h12, 8'd2},
        {1'b1, 8'h21, 8'h21, 8'd1},   // R4 R5: slot 3 shared, slot 7 own
        {1'b1, 8'h05, 8'h05, 8'd3},   // R5: slot 5 only, collides with 0x12
        {1'b1, 8'h00, 8'h00, 8'd1},   // R4: both hashes slot 0
        {1'b1, 8'h21, 8'h21, 8'd2},
        {1'b1, 8'h00, 8'h44, 8'd0},   // R5: 0x44 -> slots 8 and 0, min 0
        {1'b0, 8'h00, 8'h12, 8'd3}    // R5: over-estimate min(4,3)
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_valid = 1'b0;
    logic [7:0] ev_id = '0;
    logic [7:0] qry_id = '0;
    logic [7:0] qry_count;

    int total = 0;
    int bad   = 0;
    int edge_cnt = 0;
    bit done  = 1'b0;

    hfc_event_counter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid  (ev_valid),
        .ev_id     (ev_id),
        .qry_id    (qry_id),
        .qry_count (qry_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) edge_cnt <= 0;
        else        edge_cnt <= edge_cnt + 1;
    end

    function automatic int next_visit();
        return (edge_cnt - 1) % NSLOT;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic query_chk(input logic [7:0] id, input logic [7:0] exp, input string req);
        qry_id = id;
        #1;
        check(req, qry_count, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire(input logic [7:0] id);
        ev_valid = 1'b1;
        ev_id    = id;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic wait_visit(input int s);
        while (next_visit() != s) @(negedge clk);
    endtask

    initial begin
        idle(3);
        query_chk(8'h12, 8'd0, "R1 reset query 0x12");
        query_chk(8'h44, 8'd0, "R1 reset query 0x44");
        rst_n = 1'b1;
        idle(2);

        for (int r = 0; r < 8; r++) begin
            if (VEC[r][24]) fire(VEC[r][23:16]);
            idle(NSLOT + 2);
            query_chk(VEC[r][15:8], VEC[r][7:0], "R2 R4 R5 vector");
        end

        // R3 timing: mark slot 15 on the edge visiting 14, counted one edge later
        wait_visit(14);
        fire(8'h0F);
        query_chk(8'h0F, 8'd0, "R3 not yet visited");
        fire(8'h00);                       // edge visiting 15 marks slot 0
        query_chk(8'h0F, 8'd1, "R3 counted on visit");
        idle(1);                           // R9: next edge visits slot 0
        query_chk(8'h00, 8'd3, "R9 wrap to slot 0");

        // R7: event on the same edge as the clear keeps the mark
        wait_visit(0);
        fire(8'h0A);
        wait_visit(10);
        fire(8'h0A);
        idle(2 * NSLOT + 2);
        query_chk(8'h0A, 8'd2, "R7 event beats clear");

        // R6: three back-to-back events while slots 12/14 are not visited
        wait_visit(0);
        ev_valid = 1'b1;
        ev_id    = 8'h77;
        idle(3);
        ev_valid = 1'b0;
        idle(NSLOT + 2);
        query_chk(8'h77, 8'd1, "R6 coalesce");

        // R8: continuous events on slot 11 past the maximum
        ev_valid = 1'b1;
        ev_id    = 8'h0B;
        idle(260 * NSLOT);
        ev_valid = 1'b0;
        idle(2 * NSLOT);
        query_chk(8'h0B, 8'd255, "R8 saturate");

        rst_n = 1'b0;
        idle(1);
        query_chk(8'h0B, 8'd0, "R1 re-reset 0x0B");
        query_chk(8'h21, 8'd0, "R1 re-reset 0x21");
        rst_n = 1'b1;
        idle(2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule